// File: doc/BRIEF.md
# Load/Store Address Generator

This block is the address stage of a small 32-bit load/store core. It keeps one address register, and that register drives the external memory address bus. On a load strobe the register takes a new address from one of two inputs. The program counter (general register 15) supplies it for instruction fetch. The ALU's effective-address result supplies it for data loads and stores.

During a multi-register block transfer, the core pulses an increment strobe between beats. Each pulse moves the held address forward by one 32-bit word, so successive registers land in consecutive memory words.

Each load or increment also raises a registered valid flag for one cycle. This marks every new bus address in the order it was issued.

Top module: `addr_gen_unit`

## Requirements
- R1: While rst_ni is low, bus_addr_o is 0x0000_0000 and bus_valid_o is 0.
- R2: When load_i is high at a rising clock edge and src_sel_i is 0 (program counter), bus_addr_o equals pc_addr_i after that edge.
- R3: When load_i is high at a rising clock edge and src_sel_i is 1 (ALU result), bus_addr_o equals alu_addr_i after that edge.
- R4: When incr_i is high and load_i is low at a rising clock edge, bus_addr_o becomes its previous value plus 4, modulo 2^32, so 0xFFFF_FFFC steps to 0x0000_0000.
- R5: When load_i and incr_i are both high at the same edge, the load wins: the selected source is taken and no 4 is added.
- R6: bus_valid_o is 1 for exactly the cycle after each edge at which load_i or incr_i was high, and 0 after an edge with neither.
- R7: With load_i and incr_i both low, bus_addr_o holds its value whatever src_sel_i, pc_addr_i and alu_addr_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Load source: 0 program counter, 1 ALU result |
| load_i | input | 1 | Load the selected source into the address register |
| incr_i | input | 1 | Advance the held address by one word |
| pc_addr_i | input | 32 | Program counter value for fetch |
| alu_addr_i | input | 32 | Effective address from the ALU |
| bus_addr_o | output | 32 | Registered external address bus |
| bus_valid_o | output | 1 | High for one cycle after each load or increment |

## Verification
Colliding load and increment strobes are tested with both sources selected. A design with the wrong priority would show the loaded address plus 4, or would ignore the load.

A burst that starts at 0xFFFF_FFF8 checks the carry-out. An adder that saturates, or that is one bit too wide, would stop at the top address instead of wrapping to zero.

Idle cycles toggle every data and select input and then check that the address and valid outputs have not moved. A mux placed after the register, or a valid flag left high, would show up there.

Bursts of several increments check the word stride. A byte-stride incrementer, or one that adds nothing, would not produce the expected sequence.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  typedef enum logic {
    SRC_PC  = 1'b0,
    SRC_ALU = 1'b1
  } addr_src_e;
endpackage

// File: rtl/addr_src_mux.sv
module addr_src_mux
  import addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] alu_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    unique case (addr_src_e'(sel_i))
      SRC_ALU: addr_o = alu_i;
      default: addr_o = pc_i;
    endcase
  end
endmodule

// File: rtl/addr_incr.sv
module addr_incr #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // Carry out of the top bit is dropped: the address wraps.
  assign next_o = cur_i + STEP;
endmodule

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              incr_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic [ADDR_W-1:0] incr_val_i,
  output logic [ADDR_W-1:0] q_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= load_i | incr_i;
      if (load_i)      q_o <= load_val_i;  // load beats increment
      else if (incr_i) q_o <= incr_val_i;
    end
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import addr_gen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_sel_i,
  input  logic              load_i,
  input  logic              incr_i,
  input  logic [ADDR_W-1:0] pc_addr_i,
  input  logic [ADDR_W-1:0] alu_addr_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_valid_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] inc_addr;

  addr_src_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel_i (src_sel_i),
    .pc_i  (pc_addr_i),
    .alu_i (alu_addr_i),
    .addr_o(sel_addr)
  );

  addr_incr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_incr (
    .cur_i (bus_addr_o),
    .next_o(inc_addr)
  );

  addr_hold_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .incr_i    (incr_i),
    .load_val_i(sel_addr),
    .incr_val_i(inc_addr),
    .q_o       (bus_addr_o),
    .vld_o     (bus_valid_o)
  );

  always_comb begin
    if (!rst_ni) a_reset_r1: assert (bus_addr_o == '0 && !bus_valid_o);
  end

  p_load_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && src_sel_i == SRC_PC) |=> bus_addr_o == $past(pc_addr_i));

  p_load_alu_r3_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && src_sel_i == SRC_ALU) |=> bus_addr_o == $past(alu_addr_i));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && incr_i) |=> bus_addr_o == $past(bus_addr_o) + STEP);

  p_valid_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || incr_i) |=> bus_valid_o);

  p_valid_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !incr_i) |=> !bus_valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !incr_i) |=> $stable(bus_addr_o));
endmodule

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_sel_i = 1'b0;
  logic        load_i = 1'b0;
  logic        incr_i = 1'b0;
  logic [31:0] pc_addr_i = '0;
  logic [31:0] alu_addr_i = '0;
  logic [31:0] bus_addr_o;
  logic        bus_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  addr_gen_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_sel_i(src_sel_i), .load_i(load_i),
    .incr_i(incr_i), .pc_addr_i(pc_addr_i), .alu_addr_i(alu_addr_i),
    .bus_addr_o(bus_addr_o), .bus_valid_o(bus_valid_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, sample 1 ns after the rising edge.
  task automatic cyc(logic sel, logic ld, logic inc, logic [31:0] pc, logic [31:0] alu);
    @(negedge clk_i);
    src_sel_i = sel; load_i = ld; incr_i = inc; pc_addr_i = pc; alu_addr_i = alu;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    cyc(1'b1, 1'b1, 1'b1, 32'hAAAA_0000, 32'h5555_0000);
    chk("R1 addr in reset", bus_addr_o, 32'h0);
    chk("R1 valid in reset", {31'b0, bus_valid_o}, 32'h0);
    @(negedge clk_i);
    load_i = 1'b0; incr_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_load_pc;
    cyc(1'b0, 1'b1, 1'b0, 32'h0000_1000, 32'hDEAD_BEEF);
    chk("R2 pc load", bus_addr_o, 32'h0000_1000);
    chk("R6 valid after load", {31'b0, bus_valid_o}, 32'h1);
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R6 valid drops", {31'b0, bus_valid_o}, 32'h0);
  endtask

  task automatic t_load_alu;
    cyc(1'b1, 1'b1, 1'b0, 32'h1111_2222, 32'h8000_0040);
    chk("R3 alu load", bus_addr_o, 32'h8000_0040);
    chk("R6 valid after alu load", {31'b0, bus_valid_o}, 32'h1);
  endtask

  task automatic t_burst;
    logic [31:0] exp = 32'h0000_2000;
    cyc(1'b1, 1'b1, 1'b0, 32'h0, exp);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
      exp += 32'd4;
      chk("R4 burst step", bus_addr_o, exp);
      chk("R6 valid per beat", {31'b0, bus_valid_o}, 32'h1);
    end
  endtask

  task automatic t_wrap;
    cyc(1'b0, 1'b1, 1'b0, 32'hFFFF_FFF8, 32'h0);
    cyc(1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
    chk("R4 near top", bus_addr_o, 32'hFFFF_FFFC);
    cyc(1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
    chk("R4 wrap to zero", bus_addr_o, 32'h0);
  endtask

  task automatic t_priority;
    cyc(1'b1, 1'b1, 1'b0, 32'h0, 32'h0000_0100);
    cyc(1'b1, 1'b1, 1'b1, 32'h0, 32'h0000_3000);
    chk("R5 alu load over incr", bus_addr_o, 32'h0000_3000);
    cyc(1'b0, 1'b1, 1'b1, 32'h0000_4000, 32'h0);
    chk("R5 pc load over incr", bus_addr_o, 32'h0000_4000);
    chk("R6 valid on collision", {31'b0, bus_valid_o}, 32'h1);
  endtask

  task automatic t_hold;
    cyc(1'b0, 1'b1, 1'b0, 32'h0000_5550, 32'h0);
    for (int i = 0; i < 3; i++) begin
      cyc(i[0], 1'b0, 1'b0, 32'h1234_0000 + i, 32'hFEDC_0000 - i);
      chk("R7 hold address", bus_addr_o, 32'h0000_5550);
      chk("R6 idle valid low", {31'b0, bus_valid_o}, 32'h0);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load_pc();
    t_load_alu();
    t_burst();
    t_wrap();
    t_priority();
    t_hold();
    finish_run();
  end
endmodule